// File: doc/BRIEF.md
# Three-Phase PWM Segment Controller

This block sits between a centre-aligned PWM timing core and the gate drive pins of a three-phase inverter. It receives six raw switching signals, a high and a low signal for each of the phases A, B and C. Under a segment control word it can swap the high and low signal of any phase and can hold any single pin off. It then applies the board's active-level polarity pin and an active-low hardware trip input.

Writes to the segment word and to the three duty registers are staged and only take effect on a PWM cycle-start strobe. A duty set is committed only once all three phases have been written. A trip blanks every output at once, raises an interrupt flag and clears the block's state. Software must then rebuild the segment word and a full duty set before it can restart the outputs. A segment change is also deferred by one cycle while any phase is dropping out of a 100 % duty, so that a pin pair never changes role at the same edge as that transition.

Top module: `pwm_seg_ctrl`

## Requirements
- R1: After reset the applied segment word and all duty values are zero, the run flag and interrupt flag are clear, and every output drives the inactive level.
- R2: Segment bits 0..5 each force one output inactive for the whole cycle: bit0 CH, bit1 CL, bit2 BH, bit3 BL, bit4 AH, bit5 AL. The output vector pwm_o uses the same bit positions.
- R3: Segment bit 8 swaps the high and low signals of phase A, bit 7 those of phase B, and bit 6 those of phase C. The swap is applied before the pin masks.
- R4: A segment write (address 1, data bits 8:0) is held pending and becomes the applied word at the clock edge where cycle_start_i is high.
- R5: Duty writes go to address 2 (A), 3 (B) and 4 (C). A set is committed only after all three have been written, and the committed set appears on duty_o (A in the lowest DW bits) at the next cycle start. Incomplete sets leave duty_o unchanged.
- R6: With pol_i high an active signal drives 1. With pol_i low it drives 0. Every off, masked or blanked output drives the opposite level.
- R7: While trip_ni is low all outputs drive the inactive level in the same cycle. At the next edge the run flag clears, the interrupt flag sets, and the segment word and duty values return to zero.
- R8: A control write (address 0) with bit0 set starts the outputs, but after a trip it is ignored until a segment write and a full duty set have both followed the trip. A control write with bit1 set clears the interrupt flag.
- R9: status_o bit0 shows the live trip pin level, bit1 the interrupt flag and bit2 the polarity pin level.
- R10: At a cycle start where a phase's applied duty is all ones and the committed new value for it is not, the duties update but the pending segment word waits for the following cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DW | Register write data |
| cycle_start_i | input | 1 | One-cycle strobe at the start of each PWM period |
| raw_i | input | 6 | Raw switching signals, active high, in the R2 bit order |
| pol_i | input | 1 | Polarity pin, high selects active-high outputs |
| trip_ni | input | 1 | Hardware trip, active low |
| pwm_o | output | 6 | Gate drive outputs in the R2 bit order |
| duty_o | output | 3*DW | Applied duty values for the timing core |
| irq_o | output | 1 | Trip interrupt flag |
| status_o | output | 3 | Trip pin, interrupt flag and polarity pin |

## Verification
Two functions can meet at the same cycle-start edge: the staged segment update and the full-duty exit hold. The bench provokes this by loading an all-ones duty on phase A and applying it. It then writes a new segment word and a full duty set with a lower phase A value, and pulses the cycle start. It judges the result by observing the duty outputs update while the old pin masks still shape the outputs. The new masks must appear only after the next strobe. Random segment words, raw patterns and polarity are also checked against a bench model. A trip that lands while writes are pending is checked to clear that pending state.

// File: rtl/pwm_seg_pkg.sv
`timescale 1ns/1ps
package pwm_seg_pkg;
  localparam int N_PHASE = 3;
  localparam int N_PIN   = 2 * N_PHASE;
  localparam int SEG_W   = N_PIN + N_PHASE;
  localparam int XO_LSB  = N_PIN;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_SEG    = 3'd1;
  localparam logic [2:0] ADDR_DUTY_A = 3'd2;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/pwm_seg_regs.sv
`timescale 1ns/1ps
module pwm_seg_regs
  import pwm_seg_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 cycle_start_i,
  input  logic                 trip_ni,
  output logic [SEG_W-1:0]     seg_o,
  output logic [N_PHASE*DW-1:0] duty_o,
  output logic                 run_o,
  output logic                 irq_o
);
  logic [SEG_W-1:0] seg_pend_q, seg_q;
  logic [N_PHASE-1:0][DW-1:0] shadow_q, shadow_d, stage_q, duty_q;
  logic [N_PHASE-1:0] seen_q, seen_d;
  logic stage_vld_q, stage_vld_d;
  logic run_q, irq_q, seg_seen_q, duty_seen_q;
  logic commit, leaving;

  always_comb begin
    shadow_d = shadow_q;
    seen_d   = seen_q;
    for (int k = 0; k < N_PHASE; k++) begin
      if (wr_en_i && wr_addr_i == ADDR_DUTY_A + 3'(k)) begin
        shadow_d[k] = wr_data_i;
        seen_d[k]   = 1'b1;
      end
    end
    commit = &seen_d;
  end

  // phase dropping out of full duty at this boundary
  always_comb begin
    leaving = 1'b0;
    for (int k = 0; k < N_PHASE; k++)
      if (stage_vld_q && (&duty_q[k]) && !(&stage_q[k])) leaving = 1'b1;
  end

  always_comb begin
    if (commit)             stage_vld_d = 1'b1;
    else if (cycle_start_i) stage_vld_d = 1'b0;
    else                    stage_vld_d = stage_vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_pend_q  <= '0;
      seg_q       <= '0;
      shadow_q    <= '0;
      stage_q     <= '0;
      duty_q      <= '0;
      seen_q      <= '0;
      stage_vld_q <= 1'b0;
      run_q       <= 1'b0;
      irq_q       <= 1'b0;
      seg_seen_q  <= 1'b1;
      duty_seen_q <= 1'b1;
    end else if (!trip_ni) begin
      seg_pend_q  <= '0;
      seg_q       <= '0;
      shadow_q    <= '0;
      stage_q     <= '0;
      duty_q      <= '0;
      seen_q      <= '0;
      stage_vld_q <= 1'b0;
      run_q       <= 1'b0;
      irq_q       <= 1'b1;
      seg_seen_q  <= 1'b0;
      duty_seen_q <= 1'b0;
    end else begin
      shadow_q    <= shadow_d;
      seen_q      <= commit ? '0 : seen_d;
      stage_vld_q <= stage_vld_d;
      if (commit) begin
        stage_q     <= shadow_d;
        duty_seen_q <= 1'b1;
      end
      if (cycle_start_i && stage_vld_q) duty_q <= stage_q;
      if (cycle_start_i && !leaving)    seg_q  <= seg_pend_q;
      if (wr_en_i && wr_addr_i == ADDR_SEG) begin
        seg_pend_q <= wr_data_i[SEG_W-1:0];
        seg_seen_q <= 1'b1;
      end
      if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
        if (wr_data_i[CTRL_CLR_BIT]) irq_q <= 1'b0;
        run_q <= wr_data_i[CTRL_RUN_BIT] & seg_seen_q & duty_seen_q;
      end
    end
  end

  assign seg_o  = seg_q;
  assign duty_o = duty_q;
  assign run_o  = run_q;
  assign irq_o  = irq_q;

  assert_seg_staged_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_start_i && trip_ni) |=> $stable(seg_q));
  assert_duty_staged_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cycle_start_i && stage_vld_q) && trip_ni) |=> $stable(duty_q));
  assert_trip_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |=> (irq_q && !run_q && seg_q == '0));
  assert_full_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && trip_ni && leaving) |=> $stable(seg_q));
  assert_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seg_seen_q && !run_q && trip_ni) |=> !run_q);
endmodule

// File: rtl/pwm_seg_outpath.sv
`timescale 1ns/1ps
module pwm_seg_outpath
  import pwm_seg_pkg::*;
(
  input  logic [N_PIN-1:0] raw_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             run_i,
  input  logic             trip_ni,
  input  logic             pol_i,
  output logic [N_PIN-1:0] pwm_o
);
  logic gate_on;
  assign gate_on = run_i & trip_ni;

  // phase p: high pin 2p, low pin 2p+1 (p=0 is C, p=2 is A)
  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    localparam int HI = 2 * p;
    localparam int LO = 2 * p + 1;
    logic swap, hi_act, lo_act;
    assign swap   = seg_i[XO_LSB + p];
    assign hi_act = (swap ? raw_i[LO] : raw_i[HI]) & ~seg_i[HI] & gate_on;
    assign lo_act = (swap ? raw_i[HI] : raw_i[LO]) & ~seg_i[LO] & gate_on;
    assign pwm_o[HI] = pol_i ? hi_act : ~hi_act;
    assign pwm_o[LO] = pol_i ? lo_act : ~lo_act;
  end
endmodule

// File: rtl/pwm_seg_ctrl.sv
`timescale 1ns/1ps
module pwm_seg_ctrl
  import pwm_seg_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               cycle_start_i,
  input  logic [5:0]         raw_i,
  input  logic               pol_i,
  input  logic               trip_ni,
  output logic [5:0]         pwm_o,
  output logic [3*DW-1:0]    duty_o,
  output logic               irq_o,
  output logic [2:0]         status_o
);
  logic [SEG_W-1:0] seg;
  logic             run;

  pwm_seg_regs #(.DW(DW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .cycle_start_i (cycle_start_i),
    .trip_ni       (trip_ni),
    .seg_o         (seg),
    .duty_o        (duty_o),
    .run_o         (run),
    .irq_o         (irq_o)
  );

  pwm_seg_outpath u_out (
    .raw_i   (raw_i),
    .seg_i   (seg),
    .run_i   (run),
    .trip_ni (trip_ni),
    .pol_i   (pol_i),
    .pwm_o   (pwm_o)
  );

  assign status_o = {pol_i, irq_o, trip_ni};

  assert_trip_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> pwm_o == {6{~pol_i}});
  assert_idle_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == 6'b0) |-> pwm_o == {6{~pol_i}});
endmodule

// File: tb/pwm_seg_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_seg_ctrl_tb;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic cs = 1'b0;
  logic [5:0] raw = '0;
  logic pol = 1'b1;
  logic trip_n = 1'b1;
  logic [5:0] pwm;
  logic [3*DW-1:0] duty;
  logic irq;
  logic [2:0] status;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] m_seg = '0;
  logic [8:0] m_pend = '0;

  always #5 clk = ~clk;

  pwm_seg_ctrl #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cycle_start_i(cs), .raw_i(raw), .pol_i(pol),
    .trip_ni(trip_n), .pwm_o(pwm), .duty_o(duty), .irq_o(irq), .status_o(status)
  );

  function automatic logic [5:0] exp_pwm(input logic [5:0] r, input logic [8:0] s,
                                          input logic p, input logic on);
    logic [5:0] a;
    for (int ph = 0; ph < 3; ph++) begin
      logic h, l;
      h = s[6+ph] ? r[2*ph+1] : r[2*ph];
      l = s[6+ph] ? r[2*ph]   : r[2*ph+1];
      a[2*ph]   = h & ~s[2*ph]   & on;
      a[2*ph+1] = l & ~s[2*ph+1] & on;
    end
    return p ? a : ~a;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd1) m_pend = d[8:0];
  endtask

  task automatic cstart();
    @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic drive(input logic [5:0] r, input logic p);
    @(negedge clk);
    raw = r; pol = p;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    drive(6'h3F, 1'b1);
    chk("R1 outputs off", pwm, 6'h00);
    chk("R1 duty zero", duty, 0);
    chk("R1 irq clear", irq, 0);
    // R9 status
    chk("R9 status", status, 3'b101);
    drive(6'h3F, 1'b0);
    chk("R6 off level low pol", pwm, 6'h3F);
    chk("R9 status pol low", status, 3'b001);

    wr(3'd0, 12'h001);
    drive(6'b010101, 1'b1);
    chk("R6 active high", pwm, 6'b010101);
    drive(6'b010101, 1'b0);
    chk("R6 active low", pwm, 6'b101010);

    // R4 staging
    wr(3'd1, 12'h100);
    drive(6'b010000, 1'b1);
    chk("R4 not before strobe", pwm, 6'b010000);
    cstart(); m_seg = m_pend;
    drive(6'b010000, 1'b1);
    chk("R3 phase A swap", pwm, 6'b100000);
    wr(3'd1, 12'h0C0);
    cstart(); m_seg = m_pend;
    drive(6'b000101, 1'b1);
    chk("R3 phase B and C swap", pwm, 6'b001010);
    wr(3'd1, 12'h03F);
    cstart(); m_seg = m_pend;
    drive(6'h3F, 1'b0);
    chk("R2 all masked", pwm, 6'h3F);
    wr(3'd1, 12'h018);
    cstart(); m_seg = m_pend;
    drive(6'h3F, 1'b1);
    chk("R2 AH and BL masked", pwm, 6'b100111);

    // R5 duty commit
    wr(3'd2, 12'h111);
    wr(3'd3, 12'h222);
    cstart();
    #1 chk("R5 incomplete set", duty, 0);
    wr(3'd4, 12'h333);
    #1 chk("R5 not before strobe", duty, 0);
    cstart();
    #1 chk("R5 committed", duty, {12'h333, 12'h222, 12'h111});

    // R10 full-on exit holds the segment update
    wr(3'd2, 12'hFFF); wr(3'd3, 12'h010); wr(3'd4, 12'h020);
    cstart();
    wr(3'd1, 12'h000);
    cstart(); m_seg = m_pend;
    wr(3'd1, 12'h010);
    wr(3'd2, 12'h040); wr(3'd3, 12'h010); wr(3'd4, 12'h020);
    cstart();
    #1 chk("R10 duty updates", duty, {12'h020, 12'h010, 12'h040});
    drive(6'h3F, 1'b1);
    chk("R10 segment held", pwm, 6'h3F);
    cstart(); m_seg = m_pend;
    drive(6'h3F, 1'b1);
    chk("R10 segment next cycle", pwm, 6'b101111);

    // random segment, raw and polarity
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2) wr(3'd1, DW'($urandom % 512));
      if ($urandom % 2) begin cstart(); m_seg = m_pend; end
      drive(6'($urandom), 1'($urandom));
      chk("R2 R3 R6 random", pwm, exp_pwm(raw, m_seg, pol, 1'b1));
    end

    // R7 trip
    wr(3'd1, 12'h005);
    @(negedge clk);
    raw = 6'h3F; pol = 1'b1; trip_n = 1'b0;
    #1 chk("R7 immediate blank", pwm, 6'h00);
    chk("R9 trip pin", status[0], 0);
    @(negedge clk);
    chk("R7 irq set", irq, 1);
    chk("R7 duty cleared", duty, 0);
    trip_n = 1'b1;
    m_seg = '0; m_pend = '0;
    cstart();
    wr(3'd0, 12'h001);
    drive(6'h3F, 1'b1);
    chk("R8 enable ignored", pwm, 6'h00);
    wr(3'd1, 12'h003);
    wr(3'd0, 12'h001);
    drive(6'h3F, 1'b1);
    chk("R8 ignored without duty", pwm, 6'h00);
    wr(3'd2, 12'h050); wr(3'd3, 12'h060); wr(3'd4, 12'h070);
    wr(3'd0, 12'h003);
    chk("R8 irq cleared", irq, 0);
    drive(6'h3F, 1'b1);
    chk("R7 pending segment cleared", pwm, 6'h3F);
    cstart(); m_seg = m_pend;
    drive(6'h3F, 1'b1);
    chk("R8 restarted", pwm, exp_pwm(6'h3F, 9'h003, 1'b1, 1'b1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule